// File: doc/BRIEF.md
# Half-Rate Two-Phase Noise-Shaping Requantizer

This block reduces a wide unsigned sample stream to a few bits with high-pass shaped quantization noise. Its noise transfer function is (1 − z⁻¹)ⁿ, and n is set at elaboration to 2 or 3. It runs at half the output sample rate. Each clock it accepts one even-phase sample and one odd-phase sample. Each clock it emits two coarse codes that, read even first and odd second, form the full-rate requantized sequence.

Quantization is plain truncation. The dropped low bits are kept as the error and fed back through the loop filter 1 − NTF. The two phases are computed in one cycle as a 2×2 block structure. The odd phase uses the error that the even phase produced in the same cycle. Older errors come from a short register history. A downstream interleaver, outside this block, serialises the two codes.

Top module: `dsm_poly_top`

## Requirements
- R1: Each clock, `y_even` is the full-rate modulator output for sample 2k (input `x_even`) and `y_odd` is the output for sample 2k+1 (input `x_odd`). The even sample is the earlier one in time.
- R2: The pre-quantizer sum is v[t] = x[t] + Σ cᵢ·e[t−i]. For ORDER=3 the coefficients c₁, c₂, c₃ are +3, −3, +1. For ORDER=2 the coefficients c₁, c₂ are +2, −1.
- R3: The input is unsigned offset-binary. The code is floor(v / 2^(IN_W−OUT_W)). The error e[t] is the low IN_W−OUT_W bits of v, read as an unsigned value, and it is kept even when the code saturates.
- R4: Every clock, the error history register that feeds the odd phase takes the error of the odd sample. The register one step older takes the error of the even sample from the same cycle.
- R5: The outputs are registered. Inputs presented before a rising edge appear on `y_even`/`y_odd` right after that edge.
- R6: The code saturates to the range 0 … 2^OUT_W − 1: a negative v gives 0, and an over-range v gives the all-ones code.
- R7: Synchronous active-high `rst` clears both outputs and all error history to zero.
- R8: Over 128 consecutive samples of a constant, non-saturating input x, the sum of the codes times 2^(IN_W−OUT_W) differs from 128·x by at most 8·2^(IN_W−OUT_W).

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| x_even | input | IN_W | Earlier input sample of the pair, unsigned |
| x_odd | input | IN_W | Later input sample of the pair, unsigned |
| y_even | output | OUT_W | Code for the earlier sample |
| y_odd | output | OUT_W | Code for the later sample |

## Verification
A full-rate, one-sample-at-a-time model of the loop is fed the interleaved stream and compared with both phases on every cycle. The test uses five input patterns:
- Constant mid-scale and constant tracking inputs expose wrong coefficients through the long-run average.
- Full-scale and zero inputs drive v past both ends of the range, which shows whether the code saturates correctly and whether the error is still retained.
- Pairs that differ strongly between even and odd show a swapped phase order, and show an odd phase that uses a stale even error.
- Random data and a ramp cover general arithmetic.
- A reset in mid-stream shows whether all error history is cleared.

// File: rtl/dsm_poly_pkg.sv
package dsm_poly_pkg;

  // Signed coefficient i (1-based) of 1 - (1 - z^-1)^order.
  function automatic int tap_coef(input int order, input int idx);
    int c;
    c = 1;
    for (int k = 0; k < idx; k++) begin
      c = c * (order - k) / (k + 1);
    end
    return ((idx % 2) == 1) ? c : -c;
  endfunction

endpackage

// File: rtl/dsm_phase_slice.sv
module dsm_phase_slice
  import dsm_poly_pkg::*;
#(
  parameter int IN_W  = 13,
  parameter int OUT_W = 4,
  parameter int ORDER = 3,
  localparam int DROP = IN_W - OUT_W,
  localparam int SW   = IN_W + ORDER + 1
) (
  input  logic [IN_W-1:0]              x,
  input  logic [ORDER-1:0][DROP-1:0]   hist,   // hist[i] = e[t-1-i]
  output logic signed [SW-1:0]         v,
  output logic [OUT_W-1:0]             y,
  output logic [DROP-1:0]              err
);
  localparam int QMAX = (1 << OUT_W) - 1;
  localparam logic signed [SW-1:0] QMAX_S = SW'(QMAX);

  logic signed [SW-1:0] acc;
  logic signed [SW-1:0] coef;
  logic signed [SW-1:0] q;

  always_comb begin
    acc = $signed({{(SW-IN_W){1'b0}}, x});
    for (int i = 0; i < ORDER; i++) begin
      coef = SW'(tap_coef(ORDER, i + 1));
      acc  = acc + coef * $signed({{(SW-DROP){1'b0}}, hist[i]});
    end
  end

  assign v   = acc;
  assign q   = acc >>> DROP;
  assign err = acc[DROP-1:0];

  always_comb begin
    if (acc[SW-1])          y = '0;
    else if (q > QMAX_S)    y = OUT_W'(QMAX);
    else                    y = q[OUT_W-1:0];
  end

endmodule

// File: rtl/dsm_err_hist.sv
module dsm_err_hist #(
  parameter int DROP  = 9,
  parameter int ORDER = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [DROP-1:0]             err_even,
  input  logic [DROP-1:0]             err_odd,
  output logic [ORDER-1:0][DROP-1:0]  hist       // hist[j] = e[T-2-j], T = odd time
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hist[0] <= '0;
      hist[1] <= '0;
    end else begin
      hist[0] <= err_odd;
      hist[1] <= err_even;
    end
  end

  for (genvar j = 2; j < ORDER; j++) begin : g_older
    always_ff @(posedge clk) begin
      if (rst) hist[j] <= '0;
      else     hist[j] <= hist[j-2];
    end
  end

endmodule

// File: rtl/dsm_poly_top.sv
module dsm_poly_top #(
  parameter int IN_W  = 13,
  parameter int OUT_W = 4,
  parameter int ORDER = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  x_even,
  input  logic [IN_W-1:0]  x_odd,
  output logic [OUT_W-1:0] y_even,
  output logic [OUT_W-1:0] y_odd
);
  localparam int DROP = IN_W - OUT_W;
  localparam int SW   = IN_W + ORDER + 1;

  logic [ORDER-1:0][DROP-1:0] hist;
  logic [1:0][ORDER-1:0][DROP-1:0] ph_hist;
  logic [1:0][IN_W-1:0]  ph_x;
  logic [1:0][OUT_W-1:0] ph_y;
  logic [1:0][DROP-1:0]  ph_err;
  logic signed [SW-1:0]  v_even, v_odd;

  assign ph_x[0] = x_even;
  assign ph_x[1] = x_odd;

  // Even phase: entirely from registered history.
  assign ph_hist[0] = hist;
  // Odd phase: newest tap is this cycle's even error.
  assign ph_hist[1][0] = ph_err[0];
  for (genvar i = 1; i < ORDER; i++) begin : g_odd_hist
    assign ph_hist[1][i] = hist[i-1];
  end

  for (genvar p = 0; p < 2; p++) begin : g_phase
    logic signed [SW-1:0] v_p;
    dsm_phase_slice #(.IN_W(IN_W), .OUT_W(OUT_W), .ORDER(ORDER)) u_slice (
      .x    (ph_x[p]),
      .hist (ph_hist[p]),
      .v    (v_p),
      .y    (ph_y[p]),
      .err  (ph_err[p])
    );
  end

  assign v_even = g_phase[0].v_p;
  assign v_odd  = g_phase[1].v_p;

  dsm_err_hist #(.DROP(DROP), .ORDER(ORDER)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .err_even (ph_err[0]),
    .err_odd  (ph_err[1]),
    .hist     (hist)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      y_even <= '0;
      y_odd  <= '0;
    end else begin
      y_even <= ph_y[0];
      y_odd  <= ph_y[1];
    end
  end

endmodule

// File: rtl/dsm_poly_chk.sv
module dsm_poly_chk #(
  parameter int IN_W  = 13,
  parameter int OUT_W = 4,
  parameter int ORDER = 3,
  localparam int DROP = IN_W - OUT_W,
  localparam int SW   = IN_W + ORDER + 1
) (
  input logic                       clk,
  input logic                       rst,
  input logic signed [SW-1:0]       v_even,
  input logic signed [SW-1:0]       v_odd,
  input logic [DROP-1:0]            err_even,
  input logic [DROP-1:0]            err_odd,
  input logic [ORDER-1:0][DROP-1:0] hist,
  input logic [OUT_W-1:0]           y_even,
  input logic [OUT_W-1:0]           y_odd
);
  localparam int QMAX = (1 << OUT_W) - 1;
  localparam logic signed [SW-1:0] QMAX_S = SW'(QMAX);

  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  logic signed [SW-1:0] qe;
  logic over_even;
  assign qe        = v_even >>> DROP;
  assign over_even = !v_even[SW-1] && (qe > QMAX_S);

  p_hist_odd_r4: assert property (@(posedge clk) disable iff (rst)
    armed |-> hist[0] == $past(err_odd));

  p_hist_even_r4: assert property (@(posedge clk) disable iff (rst)
    armed |-> hist[1] == $past(err_even));

  p_sat_high_r6: assert property (@(posedge clk) disable iff (rst)
    over_even |=> y_even == OUT_W'(QMAX));

  p_sat_low_r6: assert property (@(posedge clk) disable iff (rst)
    v_odd[SW-1] |=> y_odd == '0);

  p_reset_clear_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (y_even == '0 && y_odd == '0 && hist == '0));

endmodule

bind dsm_poly_top dsm_poly_chk #(.IN_W(IN_W), .OUT_W(OUT_W), .ORDER(ORDER)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .v_even   (v_even),
  .v_odd    (v_odd),
  .err_even (ph_err[0]),
  .err_odd  (ph_err[1]),
  .hist     (hist),
  .y_even   (y_even),
  .y_odd    (y_odd)
);

// File: tb/dsm_poly_top_tb.sv
module dsm_poly_top_tb;
  localparam int IN_W  = 13;
  localparam int OUT_W = 4;
  localparam int ORDER = 3;
  localparam int DROP  = IN_W - OUT_W;
  localparam int QMAX  = (1 << OUT_W) - 1;
  localparam int XMAX  = (1 << IN_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IN_W-1:0]  x_even = '0, x_odd = '0;
  logic [OUT_W-1:0] y_even, y_odd;

  int checks = 0, fails = 0;
  int tap [1:3];
  int eh  [1:3];
  int ysum;
  bit done = 0;

  dsm_poly_top #(.IN_W(IN_W), .OUT_W(OUT_W), .ORDER(ORDER)) u_dut (
    .clk(clk), .rst(rst), .x_even(x_even), .x_odd(x_odd),
    .y_even(y_even), .y_odd(y_odd));

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Full-rate, one-sample reference (R2, R3, R6).
  task automatic ref_step(input int x, output int y);
    int v;
    v = x;
    for (int i = 1; i <= ORDER; i++) v += tap[i] * eh[i];
    for (int i = 3; i > 1; i--) eh[i] = eh[i-1];
    eh[1] = v & ((1 << DROP) - 1);
    y = v >>> DROP;
    if (y < 0) y = 0;
    if (y > QMAX) y = QMAX;
  endtask

  task automatic ref_clear();
    for (int i = 1; i <= 3; i++) eh[i] = 0;
  endtask

  // Drive one pair, step the model as even then odd (R1), compare after the edge (R5).
  task automatic pair(input string req, input int a, input int b);
    int e0, e1;
    x_even = IN_W'(a);
    x_odd  = IN_W'(b);
    ref_step(a, e0);
    ref_step(b, e1);
    @(negedge clk);
    check({req, " even"}, int'(y_even), e0);
    check({req, " odd"},  int'(y_odd),  e1);
    ysum += int'(y_even) + int'(y_odd);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    x_even = IN_W'(XMAX);
    x_odd  = IN_W'(XMAX);
    repeat (2) @(negedge clk);
    check("R7 reset even", int'(y_even), 0);
    check("R7 reset odd",  int'(y_odd),  0);
    ref_clear();
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    if (ORDER == 3) begin tap[1] = 3; tap[2] = -3; tap[3] = 1; end
    else            begin tap[1] = 2; tap[2] = -1; tap[3] = 0; end
    ref_clear();
    @(negedge clk);
    do_reset();

    // R5 / R8: constant non-saturating input, average tracks x.
    ysum = 0;
    for (int k = 0; k < 64; k++) pair("R5 const", 5000, 5000);
    begin
      int diff;
      diff = ysum * (1 << DROP) - 128 * 5000;
      if (diff < 0) diff = -diff;
      check("R8 average", (diff <= 8 * (1 << DROP)) ? 1 : 0, 1);
    end

    // R6: full-scale drives v above range; zero drives v negative.
    for (int k = 0; k < 16; k++) pair("R6 max", XMAX, XMAX);
    for (int k = 0; k < 16; k++) pair("R6 min", 0, 0);

    // R1 / R4: phases differ strongly; swapped order or stale even error shows.
    for (int k = 0; k < 32; k++) pair("R1 alt", 0, XMAX);
    for (int k = 0; k < 32; k++) pair("R4 split", 3000 + 37 * k, 700);

    // R7: mid-stream reset clears history.
    do_reset();
    for (int k = 0; k < 16; k++) pair("R7 after", 4100, 4100);

    // R3: ramp; R2: random data.
    for (int k = 0; k < 128; k++) pair("R3 ramp", (k * 64) % (XMAX + 1), (k * 64 + 32) % (XMAX + 1));
    for (int k = 0; k < 400; k++) pair("R2 rand", int'($urandom_range(XMAX, 0)), int'($urandom_range(XMAX, 0)));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule